// File: doc/BRIEF.md
# Debug Trace Status Sequencer

This block sits next to a small CPU core and turns the core's event strobes into a 4-bit processor-status code (`pst_o`) and a 4-bit debug-data nibble stream (`ddata_o`). Some statuses are held for many cycles: exception processing, stopped, halted and emulator mode. One-cycle markers are laid over them: instruction start, operand capture, taken branch, target address, return-from-exception and user-mode entry. Captured operands and branch targets go into a small FIFO. A serialiser drains the FIFO and shifts each entry out on `ddata_o`, least significant nibble first.

The block has one mode state machine with the states M_RUN, M_EXC, M_STOP, M_HALT and M_EMU, and a one-cycle target-pending flag. The transitions are:
- Exception entry moves any running state to M_EXC.
- The target marker that follows a taken branch moves M_EXC back to M_RUN.
- The stop, halt and emulator-entry strobes move a running state to M_STOP, M_HALT and M_EMU.
- The wake strobe moves any of those three states back to M_RUN.

A fixed-priority arbiter picks one event per cycle. `stall_o` asks the core to hold its strobes while the FIFO is full or a target marker is still due. All outputs are registered, so a strobe sampled at one clock edge shows on `pst_o` in the following cycle.

Top module: `trace_status_seq`

## Requirements
- R1: A synchronous reset empties the FIFO, enters M_RUN and clears the target-pending flag. In the cycle after reset, `pst_o`=0x0, `ddata_o`=0x0 and `stall_o`=0.
- R2: In M_RUN with no accepted event and no data to shift, `pst_o` and `ddata_o` are both 0x0.
- R3: An accepted instruction-start strobe gives `pst_o`=0x1 for one cycle.
- R4: Exception entry gives `pst_o`=0xC from the next cycle on. 0xC is shown on every cycle in M_EXC where no marker is due. Exception entry while already in M_EXC shows 0xC again.
- R5: An accepted operand strobe gives `pst_o`=0xB for one cycle and queues all 32 bits, which is 8 nibbles.
- R6: An accepted taken branch gives `pst_o`=0x5. The next cycle carries the target marker, chosen as follows:
  - 0x9 with 4 nibbles queued, when target bits 31:16 are zero;
  - otherwise 0xA with 6 nibbles, when bits 31:24 are zero;
  - otherwise 0xB with 8 nibbles.
  The marker cycle leaves M_EXC for M_RUN.
- R7: The serialiser takes the FIFO head on an edge where it is idle or showing its last nibble. From the next cycle it shows one nibble per clock, least significant first, with entries back to back. `ddata_o` is 0x0 when nothing is being shifted.
- R8: The stop strobe gives 0x1 and then 0xE. The halt strobe gives 0x1 and then 0xF. Each code is held until an accepted wake.
- R9: A return-from-exception strobe gives 0x7 and a user-entry strobe gives 0x3, each for one cycle, and neither changes the mode.
- R10: The emulator-entry strobe gives 0xD from the next cycle, held until an accepted wake.
- R11: In M_STOP, M_HALT and M_EMU every strobe except wake is ignored. An accepted wake returns to M_RUN with `pst_o`=0x0.
- R12: `stall_o` is high while the FIFO holds FIFO_DEPTH entries or a target marker is due. While it is high, all strobes (wake included) are ignored: they give no marker and queue nothing.
- R13: When several strobes are active in M_RUN or M_EXC, only the highest-priority one acts. The order from highest is exception, branch, operand, return-from-exception, user entry, stop, halt, emulator entry, instruction start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_i | input | 1 | Instruction start strobe |
| exc_i | input | 1 | Exception entry strobe |
| opnd_i | input | 1 | Operand capture strobe |
| opnd_data_i | input | 32 | Captured operand |
| br_i | input | 1 | Taken branch strobe |
| br_target_i | input | 32 | Branch target address |
| rte_i | input | 1 | Return-from-exception start strobe |
| user_i | input | 1 | User-mode entry strobe |
| stop_i | input | 1 | Stop instruction strobe |
| halt_i | input | 1 | Halt instruction strobe |
| emu_i | input | 1 | Emulator-mode entry strobe |
| wake_i | input | 1 | Leave stopped, halted or emulator state |
| pst_o | output | 4 | Processor status code |
| ddata_o | output | 4 | Debug data nibble |
| stall_o | output | 1 | Request to the core to hold strobes |

## Verification
The bound checker watches five properties on every cycle:
- every 0x5 is followed by a 0x9..0xB marker and comes with a stall;
- halted and emulator codes persist until a wake;
- a stalled idle cycle stays idle;
- the FIFO never exceeds its depth;
- the outputs are idle right after reset.

Some behaviour is a matter of sequence and data, and only the bench scenarios show it:
- full exception and reset-exception sequences;
- nibble order and back-to-back serialisation;
- marker choice for each target width;
- strobes being ignored while stopped or stalled;
- the priority among simultaneous strobes.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int DW    = 32;
    localparam int NIB_W = $clog2(DW / 4 + 1);

    localparam logic [3:0] PST_IDLE = 4'h0;
    localparam logic [3:0] PST_INSN = 4'h1;
    localparam logic [3:0] PST_USER = 4'h3;
    localparam logic [3:0] PST_BR   = 4'h5;
    localparam logic [3:0] PST_RTE  = 4'h7;
    localparam logic [3:0] PST_T2   = 4'h9;
    localparam logic [3:0] PST_T3   = 4'hA;
    localparam logic [3:0] PST_T4   = 4'hB;
    localparam logic [3:0] PST_EXC  = 4'hC;
    localparam logic [3:0] PST_EMU  = 4'hD;
    localparam logic [3:0] PST_STOP = 4'hE;
    localparam logic [3:0] PST_HALT = 4'hF;

    typedef enum logic [2:0] {
        M_RUN, M_EXC, M_STOP, M_HALT, M_EMU
    } mode_e;

    typedef enum logic [3:0] {
        EV_NONE, EV_EXC, EV_BR, EV_OPND, EV_RTE, EV_USER,
        EV_STOP, EV_HALT, EV_EMU, EV_INSN, EV_WAKE
    } ev_e;

    typedef struct packed {
        logic [DW-1:0]    data;
        logic [NIB_W-1:0] nibs;
    } cap_t;

    // Significant nibbles of a target: 2, 3 or 4 bytes.
    function automatic logic [NIB_W-1:0] tgt_nibs(input logic [DW-1:0] a);
        if (a[DW-1:16] == '0)      return NIB_W'(4);
        else if (a[DW-1:24] == '0) return NIB_W'(6);
        else                       return NIB_W'(8);
    endfunction

    function automatic logic [3:0] tgt_marker(input logic [NIB_W-1:0] n);
        if (n == NIB_W'(4))      return PST_T2;
        else if (n == NIB_W'(6)) return PST_T3;
        else                     return PST_T4;
    endfunction

    function automatic logic [3:0] mode_hold(input mode_e m);
        unique case (m)
            M_EXC:   return PST_EXC;
            M_STOP:  return PST_STOP;
            M_HALT:  return PST_HALT;
            M_EMU:   return PST_EMU;
            default: return PST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/trace_event_arb.sv
module trace_event_arb
    import trace_pkg::*;
(
    input  logic  stall,
    input  mode_e mode,
    input  logic  insn,
    input  logic  exc,
    input  logic  opnd,
    input  logic  br,
    input  logic  rte,
    input  logic  user,
    input  logic  stp,
    input  logic  hlt,
    input  logic  emu,
    input  logic  wake,
    output ev_e   ev
);

    always_comb begin
        ev = EV_NONE;
        if (!stall) begin
            unique case (mode)
                M_RUN, M_EXC: begin
                    if (exc)       ev = EV_EXC;
                    else if (br)   ev = EV_BR;
                    else if (opnd) ev = EV_OPND;
                    else if (rte)  ev = EV_RTE;
                    else if (user) ev = EV_USER;
                    else if (stp)  ev = EV_STOP;
                    else if (hlt)  ev = EV_HALT;
                    else if (emu)  ev = EV_EMU;
                    else if (insn) ev = EV_INSN;
                end
                M_STOP, M_HALT, M_EMU: begin
                    if (wake) ev = EV_WAKE;
                end
                default: ev = EV_NONE;
            endcase
        end
    end

endmodule

// File: rtl/trace_status_fsm.sv
module trace_status_fsm
    import trace_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ev_e           ev,
    input  logic [DW-1:0] opnd_data,
    input  logic [DW-1:0] br_target,
    output mode_e         mode,
    output logic          tgt_pend,
    output logic [3:0]    pst,
    output logic          push,
    output cap_t          push_ent
);

    mode_e      mode_q, mode_d;
    logic       tgt_pend_q, tgt_pend_d;
    logic [3:0] tgt_code_q, tgt_code_d;
    logic [3:0] pst_q, pst_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= M_RUN;
            tgt_pend_q <= 1'b0;
            tgt_code_q <= PST_IDLE;
            pst_q      <= PST_IDLE;
        end else begin
            mode_q     <= mode_d;
            tgt_pend_q <= tgt_pend_d;
            tgt_code_q <= tgt_code_d;
            pst_q      <= pst_d;
        end
    end

    // Next state
    always_comb begin
        mode_d     = mode_q;
        tgt_pend_d = 1'b0;
        tgt_code_d = tgt_code_q;
        if (tgt_pend_q && mode_q == M_EXC) mode_d = M_RUN;
        unique case (ev)
            EV_EXC:  mode_d = M_EXC;
            EV_BR: begin
                tgt_pend_d = 1'b1;
                tgt_code_d = tgt_marker(tgt_nibs(br_target));
            end
            EV_STOP: mode_d = M_STOP;
            EV_HALT: mode_d = M_HALT;
            EV_EMU:  mode_d = M_EMU;
            EV_WAKE: mode_d = M_RUN;
            default: ;
        endcase
    end

    // Outputs
    always_comb begin
        push     = 1'b0;
        push_ent = '0;
        pst_d    = mode_hold(mode_q);
        if (tgt_pend_q) begin
            pst_d = tgt_code_q;
        end else begin
            unique case (ev)
                EV_EXC:  pst_d = PST_EXC;
                EV_BR: begin
                    pst_d    = PST_BR;
                    push     = 1'b1;
                    push_ent = '{data: br_target, nibs: tgt_nibs(br_target)};
                end
                EV_OPND: begin
                    pst_d    = PST_T4;
                    push     = 1'b1;
                    push_ent = '{data: opnd_data, nibs: NIB_W'(DW / 4)};
                end
                EV_RTE:  pst_d = PST_RTE;
                EV_USER: pst_d = PST_USER;
                EV_STOP, EV_HALT, EV_INSN: pst_d = PST_INSN;
                EV_EMU:  pst_d = PST_EMU;
                EV_WAKE: pst_d = PST_IDLE;
                default: ;
            endcase
        end
    end

    assign mode     = mode_q;
    assign tgt_pend = tgt_pend_q;
    assign pst      = pst_q;

endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign count   = cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trace_serializer.sv
module trace_serializer
    import trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       empty,
    input  cap_t       head,
    output logic       pop,
    output logic [3:0] ddata
);

    logic [DW-1:0]    sh_q;
    logic [NIB_W-1:0] cnt_q;

    // Take the next entry when idle or on the last nibble.
    assign pop   = !empty && (cnt_q <= NIB_W'(1));
    assign ddata = (cnt_q != '0) ? sh_q[3:0] : 4'h0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (pop) begin
            sh_q  <= head.data;
            cnt_q <= head.nibs;
        end else if (cnt_q != '0) begin
            sh_q  <= sh_q >> 4;
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/trace_status_seq.sv
module trace_status_seq
    import trace_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        insn_i,
    input  logic        exc_i,
    input  logic        opnd_i,
    input  logic [31:0] opnd_data_i,
    input  logic        br_i,
    input  logic [31:0] br_target_i,
    input  logic        rte_i,
    input  logic        user_i,
    input  logic        stop_i,
    input  logic        halt_i,
    input  logic        emu_i,
    input  logic        wake_i,
    output logic [3:0]  pst_o,
    output logic [3:0]  ddata_o,
    output logic        stall_o
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int ENT_W = $bits(cap_t);

    mode_e            mode;
    ev_e              ev;
    logic             tgt_pend, push, pop, full, empty;
    cap_t             push_ent;
    logic [ENT_W-1:0] head_raw;
    logic [CNT_W-1:0] fifo_cnt;

    assign stall_o = full | tgt_pend;

    trace_event_arb u_arb (
        .stall (stall_o),
        .mode  (mode),
        .insn  (insn_i),
        .exc   (exc_i),
        .opnd  (opnd_i),
        .br    (br_i),
        .rte   (rte_i),
        .user  (user_i),
        .stp   (stop_i),
        .hlt   (halt_i),
        .emu   (emu_i),
        .wake  (wake_i),
        .ev    (ev)
    );

    trace_status_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .opnd_data (opnd_data_i),
        .br_target (br_target_i),
        .mode      (mode),
        .tgt_pend  (tgt_pend),
        .pst       (pst_o),
        .push      (push),
        .push_ent  (push_ent)
    );

    trace_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (push_ent),
        .pop   (pop),
        .dout  (head_raw),
        .full  (full),
        .empty (empty),
        .count (fifo_cnt)
    );

    trace_serializer u_ser (
        .clk   (clk),
        .rst   (rst),
        .empty (empty),
        .head  (cap_t'(head_raw)),
        .pop   (pop),
        .ddata (ddata_o)
    );

endmodule

// File: rtl/trace_seq_checker.sv
module trace_seq_checker #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       wake_i,
    input logic [3:0]                 pst_o,
    input logic [3:0]                 ddata_o,
    input logic                       stall_o,
    input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pst_o == 4'h0 && ddata_o == 4'h0 && !stall_o)); // R1

    AST_TARGET_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (pst_o == 4'h5) |=> (pst_o >= 4'h9 && pst_o <= 4'hB)); // R6

    AST_BRANCH_STALL: assert property (@(posedge clk) disable iff (rst)
        (pst_o == 4'h5) |-> stall_o); // R12

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pst_o == 4'hF && !wake_i) |=> (pst_o == 4'hF)); // R8

    AST_EMU_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pst_o == 4'hD && !wake_i) |=> (pst_o == 4'hD)); // R10

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (stall_o && pst_o == 4'h0) |=> (pst_o == 4'h0)); // R12

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH)); // R12

endmodule

bind trace_status_seq trace_seq_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wake_i   (wake_i),
    .pst_o    (pst_o),
    .ddata_o  (ddata_o),
    .stall_o  (stall_o),
    .fifo_cnt (fifo_cnt)
);

// File: tb/sim_trace_status_seq.sv
`timescale 1ns/1ps
module sim_trace_status_seq;

    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, insn, exc, opnd, br, rte, user, stp, hlt, emu, wake;
    logic [31:0] od, bt;
    logic [3:0]  pst, dd;
    logic        stall;

    int    checks = 0, errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference model state (mode: 0 run, 1 exc, 2 stop, 3 halt, 4 emu)
    int          m_mode;
    logic [3:0]  m_pst, m_code;
    bit          m_tgt;
    logic [31:0] qd[$];
    int          qn[$];
    logic [31:0] m_sh;
    int          m_cnt;

    trace_status_seq #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .insn_i(insn), .exc_i(exc), .opnd_i(opnd),
        .opnd_data_i(od), .br_i(br), .br_target_i(bt), .rte_i(rte),
        .user_i(user), .stop_i(stp), .halt_i(hlt), .emu_i(emu),
        .wake_i(wake), .pst_o(pst), .ddata_o(dd), .stall_o(stall)
    );

    function automatic bit m_stall();
        return (qd.size() == DEPTH) || m_tgt;
    endfunction

    function automatic logic [3:0] hold_code(int md);
        case (md)
            1: return 4'hC;
            2: return 4'hE;
            3: return 4'hF;
            4: return 4'hD;
            default: return 4'h0;
        endcase
    endfunction

    function automatic int nibs_of(logic [31:0] a);
        if (a[31:16] == 0) return 4;
        if (a[31:24] == 0) return 6;
        return 8;
    endfunction

    task automatic model_edge();
        bit st;
        int nmode;
        if (rst) begin
            m_mode = 0; m_pst = 4'h0; m_tgt = 0; m_code = 4'h0;
            qd.delete(); qn.delete(); m_sh = '0; m_cnt = 0;
            return;
        end
        st = m_stall();
        if (qd.size() > 0 && m_cnt <= 1) begin
            m_sh = qd.pop_front(); m_cnt = qn.pop_front();
        end else if (m_cnt > 0) begin
            m_sh = m_sh >> 4; m_cnt--;
        end
        nmode = m_mode;
        if (m_tgt) begin
            m_pst = m_code; m_tgt = 0;
            if (m_mode == 1) nmode = 0;
        end else if (st) begin
            m_pst = hold_code(m_mode);
        end else if (m_mode >= 2) begin
            if (wake) begin nmode = 0; m_pst = 4'h0; end
            else m_pst = hold_code(m_mode);
        end else if (exc) begin nmode = 1; m_pst = 4'hC;
        end else if (br) begin
            m_pst = 4'h5; m_tgt = 1;
            m_code = (nibs_of(bt) == 4) ? 4'h9 : (nibs_of(bt) == 6) ? 4'hA : 4'hB;
            qd.push_back(bt); qn.push_back(nibs_of(bt));
        end else if (opnd) begin
            m_pst = 4'hB; qd.push_back(od); qn.push_back(8);
        end else if (rte)  m_pst = 4'h7;
        else if (user)     m_pst = 4'h3;
        else if (stp) begin m_pst = 4'h1; nmode = 2; end
        else if (hlt) begin m_pst = 4'h1; nmode = 3; end
        else if (emu) begin m_pst = 4'hD; nmode = 4; end
        else if (insn)     m_pst = 4'h1;
        else               m_pst = hold_code(m_mode);
        m_mode = nmode;
    endtask

    task automatic chk(string what, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic cyc();
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk("pst", pst, m_pst);
        chk("ddata", dd, (m_cnt > 0) ? m_sh[3:0] : 4'h0);
        chk("stall", {3'b0, stall}, {3'b0, m_stall()});
    endtask

    task automatic clr();
        {insn, exc, opnd, br, rte, user, stp, hlt, emu, wake} = '0;
    endtask

    task automatic idle(int n);
        clr();
        repeat (n) cyc();
    endtask

    task automatic free();
        clr();
        while (m_stall()) cyc();
    endtask

    task automatic do_opnd(logic [31:0] v);
        free(); opnd = 1; od = v; cyc(); clr();
    endtask

    task automatic do_br(logic [31:0] v);
        free(); br = 1; bt = v; cyc(); clr();
    endtask

    initial begin
        #(5ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        clr(); od = '0; bt = '0; rst = 1'b1;
        @(negedge clk);
        cur_req = "R1"; cyc(); cyc();
        rst = 1'b0;
        cur_req = "R2"; idle(3);
        cur_req = "R3"; insn = 1; cyc(); idle(2);

        // Normal exception: C, B, B, B, 5, marker
        cur_req = "R4"; exc = 1; cyc(); idle(2);
        cur_req = "R5"; do_opnd(32'h1111_2222); idle(1);
        do_opnd(32'h3333_4444); do_opnd(32'h5A5A_A5A5);
        cur_req = "R6"; do_br(32'h0000_1234); idle(2);
        cur_req = "R7"; idle(30);

        // Reset-style exception: C then 5 and a 3-byte target
        cur_req = "R6"; exc = 1; cyc(); do_br(32'h00AB_CDEF); idle(16);
        do_br(32'h89AB_CDEF); idle(12);
        cur_req = "R4"; exc = 1; cyc(); exc = 1; cyc(); idle(2);
        do_br(32'h0000_00F0); idle(8);

        // Stop and halt with ignored strobes
        cur_req = "R8"; stp = 1; cyc(); idle(4);
        cur_req = "R11"; insn = 1; exc = 1; opnd = 1; od = 32'hFFFF_FFFF; cyc(); clr(); idle(3);
        cur_req = "R8"; wake = 1; cyc(); idle(2);
        hlt = 1; cyc(); idle(3);
        cur_req = "R11"; br = 1; bt = 32'h0000_0100; emu = 1; cyc(); idle(2);
        wake = 1; cyc(); idle(2);

        // Return from exception
        cur_req = "R9"; rte = 1; cyc(); clr(); do_opnd(32'hCAFE_0001);
        user = 1; cyc(); clr(); do_br(32'h0001_0000); idle(20);
        cur_req = "R10"; rte = 1; cyc(); emu = 1; cyc(); idle(5);
        cur_req = "R11"; wake = 1; cyc(); idle(2);

        // Fill the FIFO, then strobe during stall
        cur_req = "R12";
        for (int i = 0; i < 6; i++) begin opnd = 1; od = 32'h1000_0000 * i + i; cyc(); end
        clr(); insn = 1; cyc(); clr(); idle(60);

        // Priority among simultaneous strobes
        cur_req = "R13";
        exc = 1; br = 1; insn = 1; bt = 32'h0000_0042; cyc(); clr(); idle(1);
        free(); br = 1; opnd = 1; bt = 32'h0000_0777; od = 32'h2; cyc(); clr(); idle(8);
        user = 1; insn = 1; stp = 1; cyc(); clr(); idle(1);
        hlt = 1; emu = 1; insn = 1; cyc(); clr(); idle(2);
        wake = 1; cyc(); idle(20);

        // Constrained random mix
        cur_req = "R12";
        for (int n = 0; n < 3000; n++) begin
            int r;
            clr();
            r = $urandom % 16;
            od = $urandom;
            case ($urandom % 3)
                0: bt = $urandom & 32'h0000_FFFF;
                1: bt = $urandom & 32'h00FF_FFFF;
                default: bt = $urandom | 32'h0100_0000;
            endcase
            case (r)
                4: insn = 1;
                5: exc = 1;
                6: opnd = 1;
                7: br = 1;
                8: rte = 1;
                9: user = 1;
                10: stp = 1;
                11: hlt = 1;
                12: emu = 1;
                13, 14: wake = 1;
                15: begin insn = 1; opnd = 1; end
                default: ;
            endcase
            cyc();
        end
        clr(); idle(40);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule